// File: doc/BRIEF.md
# SPI Chip-Select and Sample Timing Unit

This unit sits between the byte engine of an SPI master and its pins. It owns the chip-select output and the timing around it. All of its delays count a fast reference tick, a one-cycle enable such as a 64 MHz strobe, rather than the system clock. The byte engine raises a transaction request and waits for a go signal. Before go rises, chip select has been held active for a programmable setup time. When the engine drops its request after the last SCK edge, chip select stays active for the same programmable time and then releases. In chained mode, where back-to-back transactions follow each other without software in between, chip select must then stay inactive for that time again before the next transaction may assert it.

The unit also moves the MISO capture instant. The engine reports each leading and each trailing SCK edge as a pulse that coincides with a tick. The clock phase setting chooses which of the two edges is the sampling edge. MISO is captured a programmable number of ticks after each sampling edge. A delay line of pending strobes holds one entry per outstanding edge, so a delay longer than the SCK half-period still yields exactly one captured bit per edge, in order.

Timing settings are frozen when a transaction starts. The chip-select polarity follows its input only while the unit is idle.

Top module: `spi_cs_timing`

## Requirements
- R1: After reset, `cs_o` is 1 (inactive for polarity 0), `txn_go` is 0 and `rx_valid` is 0.
- R2: When idle and `txn_req` is sampled high, `cs_o` takes the active level at that clock edge. `txn_go` rises on the (D+1)-th tick after that edge, where D is `cfg_cs_dur`.
- R3: When `txn_go` is high and `txn_req` is sampled low, `txn_go` falls at that edge. `cs_o` keeps its active level and returns to the inactive level on the (D+1)-th tick after that edge.
- R4: With `cfg_chain` = 1 and `txn_req` high again, `cs_o` stays inactive for exactly D+1 ticks before it reasserts. With `cfg_chain` = 0, `cs_o` reasserts one clock after release.
- R5: With `cfg_cs_high` = 0, the active level is 0 and the idle level is 1. With `cfg_cs_high` = 1, the active level is 1 and the idle level is 0. While idle, the idle level follows `cfg_cs_high` one clock later.
- R6: Setup, hold and gap counts advance only in cycles where `tick` is 1. With `tick` held at 0, `txn_go` does not rise.
- R7: With `cfg_cpha` = 0, pulses on `sck_lead` are sampling edges and pulses on `sck_trail` cause no capture. With `cfg_cpha` = 1, the roles are swapped.
- R8: A sampling edge on tick T with a delay of S = `cfg_rx_dly` captures `miso` on tick T+S. S = 0 captures on the edge tick itself. `rx_valid` is high for one clock after the capture, and `rx_bit` holds the captured value.
- R9: Every sampling edge yields exactly one capture, in edge order. This holds when S is larger than the spacing between edges, and also when chip select releases before the capture falls due.
- R10: `cfg_cs_dur`, `cfg_chain`, `cfg_rx_dly` and `cfg_cpha` are latched when a transaction starts. Changes made to them during the transaction do not alter that transaction's setup, hold, gap or sampling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Fast reference enable; all delays count these |
| cfg_cs_dur | input | DUR_W | Chip-select setup, hold and gap length in ticks (minus one) |
| cfg_cs_high | input | 1 | Polarity: 0 selects active-low, 1 selects active-high |
| cfg_chain | input | 1 | Enforce the deselect gap between chained transactions |
| cfg_rx_dly | input | DLY_W | MISO capture delay in ticks after the sampling edge |
| cfg_cpha | input | 1 | 0 samples on the leading edge, 1 on the trailing edge |
| txn_req | input | 1 | Transaction request from the byte engine |
| sck_lead | input | 1 | Leading SCK edge occurred on this tick |
| sck_trail | input | 1 | Trailing SCK edge occurred on this tick |
| miso | input | 1 | Serial input data |
| cs_o | output | 1 | Chip-select output |
| txn_go | output | 1 | Setup done; SCK may toggle |
| rx_bit | output | 1 | Last captured MISO bit |
| rx_valid | output | 1 | One-clock pulse when `rx_bit` is new |

## Verification
Two functions can coincide: the delayed MISO capture and the chip-select hold countdown. With the longest capture delay, a short hold and the request dropped right after the final sampling edge, chip select releases while captures are still pending in the delay line. The bench checks that every pending capture still arrives, on its computed cycle and with the expected bit. The other case is the end of the chained gap coinciding with a new start. Here the bench measures the exact deselected length and the reassertion in the same cycle.

// File: rtl/spi_cst_pkg.sv
package spi_cst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_HOLD,
    ST_GAP
  } cs_state_e;

  // pin level for a given active flag and polarity (1 = active-high)
  function automatic logic cs_level(input logic act, input logic high_act);
    return high_act ? act : ~act;
  endfunction

endpackage

// File: rtl/spi_tick_down.sv
module spi_tick_down #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic         is_zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (ld)                   cnt_q <= ld_val;
    else if (dec && cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
  import spi_cst_pkg::*;
#(
  parameter int DUR_W   = 8,
  parameter int RST_DUR = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             req,
  input  logic [DUR_W-1:0] cfg_dur,
  input  logic             cfg_high,
  input  logic             cfg_chain,
  output logic             cs_o,
  output logic             go,
  output logic             start
);

  cs_state_e        st_q, st_n;
  logic             act_q, act_n;
  logic             pol_q, pol_n;
  logic             go_q, go_n;
  logic             chain_q, chain_n;
  logic [DUR_W-1:0] dur_q, dur_n;
  logic             cs_q;

  logic             cnt_ld, cnt_dec, cnt_zero;
  logic [DUR_W-1:0] cnt_val;
  logic             expire;

  spi_tick_down #(.W(DUR_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .ld      (cnt_ld),
    .ld_val  (cnt_val),
    .dec     (cnt_dec),
    .is_zero (cnt_zero)
  );

  assign expire = tick && cnt_zero;

  always_comb begin
    st_n    = st_q;
    act_n   = act_q;
    pol_n   = pol_q;
    go_n    = go_q;
    chain_n = chain_q;
    dur_n   = dur_q;
    cnt_ld  = 1'b0;
    cnt_val = dur_q;
    cnt_dec = 1'b0;
    start   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        pol_n = cfg_high;
        if (req) begin
          start   = 1'b1;
          act_n   = 1'b1;
          dur_n   = cfg_dur;
          chain_n = cfg_chain;
          cnt_ld  = 1'b1;
          cnt_val = cfg_dur;
          st_n    = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (expire) begin
          go_n = 1'b1;
          st_n = ST_ACTIVE;
        end else begin
          cnt_dec = tick;
        end
      end
      ST_ACTIVE: begin
        if (!req) begin
          go_n    = 1'b0;
          cnt_ld  = 1'b1;
          cnt_val = dur_q;
          st_n    = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (expire) begin
          act_n = 1'b0;
          if (chain_q) begin
            cnt_ld  = 1'b1;
            cnt_val = dur_q;
            st_n    = ST_GAP;
          end else begin
            st_n = ST_IDLE;
          end
        end else begin
          cnt_dec = tick;
        end
      end
      ST_GAP: begin
        if (expire) begin
          if (req) begin
            start   = 1'b1;
            act_n   = 1'b1;
            dur_n   = cfg_dur;
            chain_n = cfg_chain;
            cnt_ld  = 1'b1;
            cnt_val = cfg_dur;
            st_n    = ST_SETUP;
          end else begin
            st_n = ST_IDLE;
          end
        end else begin
          cnt_dec = tick;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      act_q   <= 1'b0;
      pol_q   <= 1'b0;
      go_q    <= 1'b0;
      chain_q <= 1'b0;
      dur_q   <= DUR_W'(RST_DUR);
      cs_q    <= cs_level(1'b0, 1'b0);
    end else begin
      st_q    <= st_n;
      act_q   <= act_n;
      pol_q   <= pol_n;
      go_q    <= go_n;
      chain_q <= chain_n;
      dur_q   <= dur_n;
      cs_q    <= cs_level(act_n, pol_n);
    end
  end

  assign cs_o = cs_q;
  assign go   = go_q;

endmodule

// File: rtl/spi_miso_tap.sv
module spi_miso_tap #(
  parameter int DLY_W   = 3,
  parameter int RST_DLY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [DLY_W-1:0] cfg_dly,
  input  logic             cfg_cpha,
  input  logic             sck_lead,
  input  logic             sck_trail,
  input  logic             miso,
  output logic             rx_bit,
  output logic             rx_valid
);

  localparam int DEPTH  = 1 << DLY_W;
  localparam int STAGES = DEPTH - 1;

  logic [DLY_W-1:0]  dly_q;
  logic              cpha_q;
  logic              samp_edge;
  logic [STAGES-1:0] pend_q;
  logic [STAGES-1:0] feed;
  logic              hit;
  logic              bit_q, vld_q;

  assign samp_edge = cpha_q ? sck_trail : sck_lead;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign feed[g] = samp_edge;
    end else begin : g_body
      assign feed[g] = pend_q[g-1];
    end
  end

  always_comb begin
    if (dly_q == '0) hit = samp_edge;
    else             hit = pend_q[dly_q - DLY_W'(1)];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q  <= DLY_W'(RST_DLY);
      cpha_q <= 1'b0;
      pend_q <= '0;
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      if (start) begin
        dly_q  <= cfg_dly;
        cpha_q <= cfg_cpha;
      end
      if (tick) pend_q <= feed;
      vld_q <= tick && hit;
      if (tick && hit) bit_q <= miso;
    end
  end

  assign rx_bit   = bit_q;
  assign rx_valid = vld_q;

endmodule

// File: rtl/spi_cs_timing.sv
module spi_cs_timing #(
  parameter int DUR_W   = 8,
  parameter int DLY_W   = 3,
  parameter int RST_DUR = 2,
  parameter int RST_DLY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [DUR_W-1:0] cfg_cs_dur,
  input  logic             cfg_cs_high,
  input  logic             cfg_chain,
  input  logic [DLY_W-1:0] cfg_rx_dly,
  input  logic             cfg_cpha,
  input  logic             txn_req,
  input  logic             sck_lead,
  input  logic             sck_trail,
  input  logic             miso,
  output logic             cs_o,
  output logic             txn_go,
  output logic             rx_bit,
  output logic             rx_valid
);

  logic txn_start;

  spi_cs_seq #(.DUR_W(DUR_W), .RST_DUR(RST_DUR)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .req       (txn_req),
    .cfg_dur   (cfg_cs_dur),
    .cfg_high  (cfg_cs_high),
    .cfg_chain (cfg_chain),
    .cs_o      (cs_o),
    .go        (txn_go),
    .start     (txn_start)
  );

  spi_miso_tap #(.DLY_W(DLY_W), .RST_DLY(RST_DLY)) u_tap (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .start     (txn_start),
    .cfg_dly   (cfg_rx_dly),
    .cfg_cpha  (cfg_cpha),
    .sck_lead  (sck_lead),
    .sck_trail (sck_trail),
    .miso      (miso),
    .rx_bit    (rx_bit),
    .rx_valid  (rx_valid)
  );

endmodule

// File: rtl/spi_cs_timing_chk.sv
module spi_cs_timing_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic txn_req,
  input logic txn_go,
  input logic cs_o,
  input logic rx_valid
);

  // R2: go only rises after a request was present
  a_r2_go_after_req: assert property (@(posedge clk) disable iff (rst)
    $rose(txn_go) |-> $past(txn_req));

  // R2 / R3: chip select does not move while go is high
  a_r2_cs_steady_with_go: assert property (@(posedge clk) disable iff (rst)
    txn_go |-> $stable(cs_o));

  // R3: go drops one clock after the request is withdrawn
  a_r3_go_drops: assert property (@(posedge clk) disable iff (rst)
    (txn_go && !txn_req) |=> !txn_go);

  // R6: setup expiry only on a tick
  a_r6_go_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(txn_go) |-> $past(tick));

  // R8: a capture only happens on a tick
  a_r8_capture_on_tick: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> $past(tick));

endmodule

bind spi_cs_timing spi_cs_timing_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .txn_req  (txn_req),
  .txn_go   (txn_go),
  .cs_o     (cs_o),
  .rx_valid (rx_valid)
);

// File: tb/sim_spi_cs_timing.sv
module sim_spi_cs_timing;

  localparam int DUR_W = 8;
  localparam int DLY_W = 3;
  localparam logic [31:0] PAT = 32'hB4E1_69C3;
  localparam int NVEC = 5;
  // {dur[9:2], high_active[1], chain[0]}
  localparam logic [9:0] VEC [NVEC] = '{
    {8'd2, 1'b0, 1'b1},
    {8'd0, 1'b1, 1'b0},
    {8'd5, 1'b1, 1'b1},
    {8'd1, 1'b0, 1'b0},
    {8'd9, 1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1;
  logic [DUR_W-1:0] cfg_cs_dur = 8'd2;
  logic cfg_cs_high = 1'b0;
  logic cfg_chain = 1'b0;
  logic [DLY_W-1:0] cfg_rx_dly = 3'd2;
  logic cfg_cpha = 1'b0;
  logic txn_req = 1'b0;
  logic sck_lead = 1'b0;
  logic sck_trail = 1'b0;
  logic miso = 1'b0;
  logic cs_o, txn_go, rx_bit, rx_valid;

  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;
  int exp_cyc [64];
  int exp_n = 0;
  int got_n = 0;
  int wd = 0;
  bit done = 1'b0;

  spi_cs_timing #(.DUR_W(DUR_W), .DLY_W(DLY_W)) u0 (
    .clk(clk), .rst(rst), .tick(tick),
    .cfg_cs_dur(cfg_cs_dur), .cfg_cs_high(cfg_cs_high), .cfg_chain(cfg_chain),
    .cfg_rx_dly(cfg_rx_dly), .cfg_cpha(cfg_cpha),
    .txn_req(txn_req), .sck_lead(sck_lead), .sck_trail(sck_trail), .miso(miso),
    .cs_o(cs_o), .txn_go(txn_go), .rx_bit(rx_bit), .rx_valid(rx_valid)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    wd  <= wd + 1;
    if (wd > 150000 && !done) begin
      done = 1'b1;
      n_err++;
      $display("FAIL watchdog: act %0d exp %0d", wd, 150000);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  always @(negedge clk) miso = PAT[cyc % 32];

  // capture monitor (R8, R9)
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      n_chk++;
      if (got_n >= exp_n) begin
        n_err++;
        $display("FAIL R7 unexpected capture at cyc: act %0d exp none", cyc);
      end else if (cyc != exp_cyc[got_n] || rx_bit != PAT[(cyc - 1) % 32]) begin
        n_err++;
        $display("FAIL R8 capture: act cyc %0d bit %0b exp cyc %0d bit %0b",
                 cyc, rx_bit, exp_cyc[got_n], PAT[(cyc - 1) % 32]);
      end
      got_n++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: act %0d exp %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cs(input logic lvl);
    for (int i = 0; i < 600 && cs_o != lvl; i++) @(negedge clk);
  endtask

  task automatic wait_go();
    for (int i = 0; i < 600 && !txn_go; i++) @(negedge clk);
  endtask

  task automatic run_vec(input int dur, input logic hi, input logic ch);
    int k, gc, k2, d0, r0;
    cfg_cs_dur = DUR_W'(dur); cfg_cs_high = hi; cfg_chain = ch;
    @(negedge clk); @(negedge clk);
    check(cs_o == ~hi, "R5 idle level", int'(cs_o), int'(~hi));
    k = cyc; txn_req = 1'b1;
    @(negedge clk);
    check(cs_o == hi && cyc == k + 1, "R2 cs asserts", int'(cs_o), int'(hi));
    wait_go();
    gc = cyc;
    check(gc - (k + 1) == dur + 1, "R2 setup ticks", gc - (k + 1), dur + 1);
    // R10: retune mid-transaction; old values must govern hold and gap
    cfg_cs_dur = DUR_W'(dur + 3); cfg_chain = ~ch;
    repeat (3) @(negedge clk);
    k2 = cyc; txn_req = 1'b0;
    @(negedge clk);
    check(txn_go == 1'b0 && cs_o == hi, "R3 go falls cs held", int'(txn_go), 0);
    txn_req = 1'b1;
    wait_cs(~hi);
    d0 = cyc;
    check(d0 - k2 == dur + 2, "R3 R10 hold ticks", d0 - k2, dur + 2);
    wait_cs(hi);
    r0 = cyc;
    check(r0 - d0 == (ch ? dur + 1 : 1), "R4 R10 deselect gap", r0 - d0, ch ? dur + 1 : 1);
    wait_go();
    txn_req = 1'b0;
    @(negedge clk);
    wait_cs(~hi);
    repeat (2 * dur + 12) @(negedge clk);
  endtask

  task automatic start_txn(input int dly, input logic ph);
    cfg_cs_dur = 8'd1; cfg_cs_high = 1'b0; cfg_chain = 1'b0;
    cfg_rx_dly = DLY_W'(dly); cfg_cpha = ph;
    txn_req = 1'b1;
    @(negedge clk);
    wait_go();
  endtask

  task automatic end_txn(input string tag);
    txn_req = 1'b0;
    @(negedge clk);
    wait_cs(1'b1);
    repeat (14) @(negedge clk);
    check(got_n == exp_n, tag, got_n, exp_n);
  endtask

  task automatic pulse(input bit lead, input bit counted, input int d, input int gap);
    if (lead) sck_lead = 1'b1; else sck_trail = 1'b1;
    if (counted) begin
      exp_cyc[exp_n] = cyc + 1 + d;
      exp_n++;
    end
    @(negedge clk);
    sck_lead = 1'b0; sck_trail = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cs_o == 1'b1, "R1 cs idle", int'(cs_o), 1);
    check(txn_go == 1'b0, "R1 go low", int'(txn_go), 0);
    check(rx_valid == 1'b0, "R1 no capture", int'(rx_valid), 0);

    for (int v = 0; v < NVEC; v++)
      run_vec(int'(VEC[v][9:2]), VEC[v][1], VEC[v][0]);

    // R5 live polarity while idle
    cfg_cs_high = 1'b1; @(negedge clk); @(negedge clk);
    check(cs_o == 1'b0, "R5 idle follows polarity", int'(cs_o), 0);
    cfg_cs_high = 1'b0; @(negedge clk); @(negedge clk);
    check(cs_o == 1'b1, "R5 idle back high", int'(cs_o), 1);

    // R6 tick freeze
    begin
      int m;
      cfg_cs_dur = 8'd3; cfg_chain = 1'b0;
      txn_req = 1'b1; tick = 1'b0;
      repeat (20) @(negedge clk);
      check(txn_go == 1'b0 && cs_o == 1'b0, "R6 frozen without tick", int'(txn_go), 0);
      m = cyc; tick = 1'b1;
      wait_go();
      check(cyc - m == 4, "R6 resumes on tick", cyc - m, 4);
      txn_req = 1'b0; @(negedge clk); wait_cs(1'b1); repeat (6) @(negedge clk);
    end

    // R8 R7: delay 0 on leading edges, trailing ignored
    start_txn(0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      pulse(1'b1, 1'b1, 0, 2);
      pulse(1'b0, 1'b0, 0, 2);
    end
    end_txn("R8 R7 delay0 lead count");

    // R7 R8: cpha 1, delay 3, leading ignored
    start_txn(3, 1'b1);
    for (int i = 0; i < 3; i++) begin
      pulse(1'b1, 1'b0, 3, 3);
      pulse(1'b0, 1'b1, 3, 3);
    end
    end_txn("R7 R8 trail count");

    // R9: delay 7 beyond edge spacing, release before captures finish
    start_txn(7, 1'b0);
    for (int i = 0; i < 6; i++) begin
      pulse(1'b1, 1'b1, 7, 1);
      pulse(1'b0, 1'b0, 7, 1);
    end
    end_txn("R9 one capture per edge");

    // R10: sampling settings frozen at start
    start_txn(2, 1'b0);
    cfg_rx_dly = 3'd6; cfg_cpha = 1'b1;
    for (int i = 0; i < 4; i++) begin
      pulse(1'b1, 1'b1, 2, 2);
      pulse(1'b0, 1'b0, 2, 2);
    end
    end_txn("R10 latched sampling");

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule